// File: doc/BRIEF.md
# Sparse-Space Bus Address Translator

This block takes single host accesses aimed at a sparse address region and turns each one into one cycle on a 32-bit expansion bus. In sparse space every bus byte location is spread over a 32-byte stride of host addresses. The transfer size and the starting byte lane are therefore carried in low host address bits, not on separate wires. The block works out which of two fixed windows the host address falls in, I/O or memory. From the offset it rebuilds the bus address, the byte enables and the lane-aligned write data. On a read it shifts the returned bus data back down to bit 0.

Memory-space bus addresses are wider than the host offset can supply. Their top bits come from a high-address extension register, which is loaded through a one-cycle write strobe. Requests that cannot be carried get an error response and never reach the bus. These are addresses outside both windows, the reserved size code, and a 16-bit access that would cross the top lane. The block handles one request at a time: accept, bus cycle until acknowledge, one-cycle response.

Top module: `sparse_xlat`

## Requirements
- R1: Host address bits [35:32] select the window: 0xA is I/O space (bus_space=0), 0x2 is memory space (bus_space=1); bits [31:0] are the window offset.
- R2: The bus address bits [26:0] equal offset bits [31:5]; for I/O space bus address bits [31:27] are zero.
- R3: For memory space, bus address bits [31:27] come from the 5-bit extension register, which is zero after reset.
- R4: An extension-register write in the same cycle as a request's acceptance, or later, does not change that request; the next accepted request uses the new value.
- R5: Offset bits [4:3] give the size (00 byte, 01 16-bit word, 11 32-bit longword) and bus address bits [1:0] the lane L; active-high byte enables are 1<<L for a byte, 3<<L for a word and 4'hF for a longword.
- R6: On a write, a byte puts wdata[7:0] on lane L, a word puts wdata[15:0] on lanes L and L+1, a longword passes wdata unchanged; disabled lanes carry zero.
- R7: A successful read returns the enabled lanes shifted down to bit 0 and zero-extended (longword unchanged); a successful write returns zero data.
- R8: Size code 10 gives an error response and issues no bus cycle.
- R9: A word access with lane 3 gives an error response and issues no bus cycle.
- R10: An address outside both windows gives an error response, and every error response carries read data 0xFFFFFFFF.
- R11: host_ready is high only while idle. A bus request holds its space, address, enables and data stable until bus_ack. The response is a single-cycle host_rsp_valid pulse, one cycle after acknowledge for a bus cycle, or one cycle after acceptance for an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Block can accept a request |
| host_addr | input | 36 | Host address (window tag and offset) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 32 | Host write data, right-aligned |
| host_rsp_valid | output | 1 | Response pulse |
| host_rsp_err | output | 1 | Response is an error |
| host_rdata | output | 32 | Response read data |
| ext_we | input | 1 | Extension register write strobe |
| ext_wdata | input | 5 | Extension register write value |
| bus_req | output | 1 | Bus cycle requested |
| bus_space | output | 1 | 0 = I/O, 1 = memory |
| bus_addr | output | 32 | Bus byte address |
| bus_be | output | 4 | Active-high byte enables |
| bus_wr | output | 1 | Bus cycle is a write |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_ack | input | 1 | Bus cycle complete |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |

## Verification
The assertions assume the bus side behaves: bus_ack arrives only while bus_req is high, and bus_rdata is meaningful only in that cycle. They also assume host_valid is only looked at while host_ready is high. The bench keeps to this. It raises a request only from idle and holds bus_ack for exactly one cycle after it has seen bus_req. It also leaves one cycle of no acknowledge first, so that the stability of the held request is exercised.

// File: rtl/sx_pkg.sv
package sx_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SX_IDLE = 2'd0,
        SX_BUS  = 2'd1,
        SX_RESP = 2'd2
    } sx_state_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;
    localparam logic [1:0] SZ_RSVD = 2'b10;
    localparam logic [1:0] SZ_LONG = 2'b11;
endpackage

// File: rtl/sx_decode.sv
module sx_decode
    import sx_pkg::*;
#(
    parameter int HADDR_W   = 36,
    parameter int MEM_LOW_W = 27,
    parameter int BUS_W     = 32,
    parameter int IO_TAG    = 10,
    parameter int MEM_TAG   = 2
) (
    input  logic [HADDR_W-1:0]         haddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [BUS_W-MEM_LOW_W-1:0] ext,
    output logic                       space,
    output logic                       err,
    output logic [BUS_W-1:0]           baddr,
    output logic [LANES-1:0]           be,
    output logic [DATA_W-1:0]          bwdata,
    output logic [1:0]                 size,
    output logic [1:0]                 lane
);
    localparam int OFS_W = MEM_LOW_W + 5;
    localparam int TAG_W = HADDR_W - OFS_W;
    localparam int EXT_W = BUS_W - MEM_LOW_W;

    logic [TAG_W-1:0]     tag;
    logic [MEM_LOW_W-1:0] low;
    logic                 io_hit, mem_hit;
    logic                 unused_low;

    assign tag        = haddr[HADDR_W-1:OFS_W];
    assign low        = haddr[OFS_W-1:5];
    assign size       = haddr[4:3];
    assign lane       = low[1:0];
    assign unused_low = ^haddr[2:0];

    assign io_hit  = (tag == TAG_W'(IO_TAG));
    assign mem_hit = (tag == TAG_W'(MEM_TAG));
    assign space   = mem_hit;

    always_comb begin
        err = !(io_hit || mem_hit) || (size == SZ_RSVD)
              || (size == SZ_WORD && lane == 2'd3);
        if (mem_hit) baddr = {ext, low};
        else         baddr = {{EXT_W{1'b0}}, low};
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic en;
        always_comb begin
            case (size)
                SZ_BYTE: en = (lane == 2'(i));
                SZ_WORD: en = (lane == 2'(i)) || (lane + 2'd1 == 2'(i) && lane != 2'd3);
                SZ_LONG: en = 1'b1;
                default: en = 1'b0;
            endcase
            if (err) en = 1'b0;
        end
        assign be[i] = en;
        always_comb begin
            if (!en)                       bwdata[8*i +: 8] = 8'h00;
            else if (size == SZ_LONG)      bwdata[8*i +: 8] = wdata[8*i +: 8];
            else if (lane == 2'(i))        bwdata[8*i +: 8] = wdata[7:0];
            else                           bwdata[8*i +: 8] = wdata[15:8];
        end
    end
endmodule

// File: rtl/sx_rdalign.sv
module sx_rdalign
    import sx_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        size,
    input  logic [1:0]        lane,
    output logic [DATA_W-1:0] aligned
);
    logic [DATA_W-1:0] shifted;
    logic              unused_hi;

    assign shifted   = rdata >> {lane, 3'b000};
    assign unused_hi = ^shifted[DATA_W-1:16];

    always_comb begin
        case (size)
            SZ_BYTE: aligned = {{(DATA_W-8){1'b0}},  shifted[7:0]};
            SZ_WORD: aligned = {{(DATA_W-16){1'b0}}, shifted[15:0]};
            SZ_LONG: aligned = rdata;
            default: aligned = '0;
        endcase
    end
endmodule

// File: rtl/sparse_xlat.sv
module sparse_xlat
    import sx_pkg::*;
#(
    parameter int HADDR_W   = 36,
    parameter int MEM_LOW_W = 27,
    parameter int BUS_W     = 32,
    parameter int IO_TAG    = 10,
    parameter int MEM_TAG   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_valid,
    output logic                       host_ready,
    input  logic [HADDR_W-1:0]         host_addr,
    input  logic                       host_write,
    input  logic [31:0]                host_wdata,
    output logic                       host_rsp_valid,
    output logic                       host_rsp_err,
    output logic [31:0]                host_rdata,
    input  logic                       ext_we,
    input  logic [BUS_W-MEM_LOW_W-1:0] ext_wdata,
    output logic                       bus_req,
    output logic                       bus_space,
    output logic [BUS_W-1:0]           bus_addr,
    output logic [3:0]                 bus_be,
    output logic                       bus_wr,
    output logic [31:0]                bus_wdata,
    input  logic                       bus_ack,
    input  logic [31:0]                bus_rdata
);
    localparam int EXT_W = BUS_W - MEM_LOW_W;

    typedef struct packed {
        sx_state_e          st;
        logic               space;
        logic [BUS_W-1:0]   addr;
        logic [LANES-1:0]   be;
        logic               wr;
        logic [DATA_W-1:0]  wdata;
        logic [1:0]         size;
        logic [1:0]         lane;
        logic               err;
        logic [DATA_W-1:0]  rdata;
        logic [EXT_W-1:0]   ext;
    } regs_t;

    regs_t d, q;

    logic               dec_space, dec_err;
    logic [BUS_W-1:0]   dec_addr;
    logic [LANES-1:0]   dec_be;
    logic [DATA_W-1:0]  dec_wdata, rd_aligned;
    logic [1:0]         dec_size, dec_lane;

    sx_decode #(
        .HADDR_W(HADDR_W), .MEM_LOW_W(MEM_LOW_W), .BUS_W(BUS_W),
        .IO_TAG(IO_TAG), .MEM_TAG(MEM_TAG)
    ) u_dec (
        .haddr(host_addr), .wdata(host_wdata), .ext(q.ext),
        .space(dec_space), .err(dec_err), .baddr(dec_addr),
        .be(dec_be), .bwdata(dec_wdata), .size(dec_size), .lane(dec_lane)
    );

    sx_rdalign u_rd (
        .rdata(bus_rdata), .size(q.size), .lane(q.lane), .aligned(rd_aligned)
    );

    always_comb begin
        d = q;
        if (ext_we) d.ext = ext_wdata;
        case (q.st)
            SX_IDLE: begin
                if (host_valid) begin
                    d.space = dec_space;
                    d.addr  = dec_addr;
                    d.be    = dec_be;
                    d.wr    = host_write;
                    d.wdata = dec_wdata;
                    d.size  = dec_size;
                    d.lane  = dec_lane;
                    d.err   = dec_err;
                    d.rdata = '1;
                    d.st    = dec_err ? SX_RESP : SX_BUS;
                end
            end
            SX_BUS: begin
                if (bus_ack) begin
                    d.rdata = q.wr ? '0 : rd_aligned;
                    d.st    = SX_RESP;
                end
            end
            default: d.st = SX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_ready     = (q.st == SX_IDLE);
    assign host_rsp_valid = (q.st == SX_RESP);
    assign host_rsp_err   = q.err;
    assign host_rdata     = q.rdata;
    assign bus_req        = (q.st == SX_BUS);
    assign bus_space      = q.space;
    assign bus_addr       = q.addr;
    assign bus_be         = q.be;
    assign bus_wr         = q.wr;
    assign bus_wdata      = q.wdata;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_be)
                                 && $stable(bus_wdata) && $stable(bus_space) && $stable(bus_wr));
    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_valid |=> !host_rsp_valid);
    assert_err_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rsp_valid && host_rsp_err |-> host_rdata == 32'hFFFF_FFFF);
    assert_io_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_space |-> bus_addr[BUS_W-1:MEM_LOW_W] == '0);
    assert_be_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 || bus_be == 4'hF));
    assert_no_bus_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && host_ready && dec_err |=> !bus_req && host_rsp_valid);
endmodule

// File: tb/tb_sparse_xlat.sv
module tb_sparse_xlat;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [35:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_rsp_valid, host_rsp_err;
    logic [31:0] host_rdata;
    logic        ext_we = 1'b0;
    logic [4:0]  ext_wdata = '0;
    logic        bus_req, bus_space, bus_wr;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int vectors = 0, fails = 0;
    bit done = 1'b0;
    logic [4:0] ext_model = '0;

    always #10 clk = ~clk;

    sparse_xlat dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic [35:0] a, input logic wr, input logic [31:0] wd,
                        input logic [31:0] brd, input logic poke, input logic [4:0] pval);
        logic [3:0]  tag  = a[35:32];
        logic [1:0]  size = a[4:3];
        logic [1:0]  lane = a[6:5];
        logic        mem  = (tag == 4'h2);
        logic        hit  = (tag == 4'hA) || mem;
        logic        err  = !hit || size == 2'b10 || (size == 2'b01 && lane == 2'd3);
        logic [31:0] exp_addr = mem ? {ext_model, a[31:5]} : {5'b0, a[31:5]};
        logic [3:0]  exp_be;
        logic [31:0] exp_wd, exp_rd;
        logic [31:0] sh = brd >> (8 * lane);
        case (size)
            2'b00: begin exp_be = 4'b0001 << lane; exp_wd = {24'b0, wd[7:0]} << (8*lane);  exp_rd = {24'b0, sh[7:0]}; end
            2'b01: begin exp_be = 4'b0011 << lane; exp_wd = {16'b0, wd[15:0]} << (8*lane); exp_rd = {16'b0, sh[15:0]}; end
            default: begin exp_be = 4'hF; exp_wd = wd; exp_rd = brd; end
        endcase
        if (wr) exp_rd = '0;
        @(negedge clk);
        chk("R11 ready when idle", 32'(host_ready), 1);
        host_valid = 1'b1; host_addr = a; host_write = wr; host_wdata = wd;
        if (poke) begin ext_we = 1'b1; ext_wdata = pval; end
        @(negedge clk);
        host_valid = 1'b0; ext_we = 1'b0;
        if (err) begin
            chk(!hit ? "R10 outside window err" : (size == 2'b10 ? "R8 reserved size err" : "R9 word lane3 err"),
                {30'b0, host_rsp_valid, host_rsp_err}, 32'h3);
            chk("R8 R9 R10 no bus cycle", 32'(bus_req), 0);
            chk("R10 error data ones", host_rdata, 32'hFFFF_FFFF);
        end else begin
            chk("R11 bus request", 32'(bus_req), 1);
            chk("R1 space", 32'(bus_space), 32'(mem));
            chk(mem ? "R3 mem address" : "R2 io address", bus_addr, exp_addr);
            chk("R5 byte enables", 32'(bus_be), 32'(exp_be));
            chk("R11 bus wr", 32'(bus_wr), 32'(wr));
            if (wr) chk("R6 write lanes", bus_wdata, exp_wd);
            @(negedge clk);
            chk("R11 held request", {bus_req, bus_addr[30:0]}, {1'b1, exp_addr[30:0]});
            chk("R11 no early rsp", 32'(host_rsp_valid), 0);
            if (poke) chk("R4 ext write not applied in flight", bus_addr, exp_addr);
            bus_ack = 1'b1; bus_rdata = brd;
            @(negedge clk);
            bus_ack = 1'b0; bus_rdata = 32'hDEAD_BEEF;
            chk("R11 rsp after ack", {30'b0, host_rsp_valid, host_rsp_err}, 32'h2);
            chk("R7 read data", host_rdata, exp_rd);
        end
        if (poke) ext_model = pval;
        @(negedge clk);
        chk("R11 single-cycle rsp", 32'(host_rsp_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset ready", {29'b0, host_ready, bus_req, host_rsp_valid}, 32'h4);
        // R3: extension register resets to zero, first memory access shows it
        xact({4'h2, 25'h1ABCDEF, 2'd0, 2'b11, 3'b0}, 1'b0, 0, 32'h1234_5678, 1'b0, 0);
        for (int sp = 0; sp < 3; sp++) begin
            logic [3:0] tag = (sp == 0) ? 4'hA : (sp == 1 ? 4'h2 : 4'h5);
            if (sp == 1) xact({4'hA, 32'h0000_0018}, 1'b0, 0, 0, 1'b1, 5'h15);
            for (int sz = 0; sz < 4; sz++)
                for (int ln = 0; ln < 4; ln++)
                    for (int w = 0; w < 2; w++) begin
                        int k = sp*32 + sz*8 + ln*2 + w;
                        logic [24:0] hi = 25'(k * 32'h9E3779B + 32'h55);
                        xact({tag, hi, 2'(ln), 2'(sz), 3'b101}, w[0], 32'hA5C3_0000 ^ 32'(k * 32'h01010B07),
                             32'h8877_6655 + 32'(k * 32'h11121314), 1'b0, 0);
                    end
        end
        // R4: write in the acceptance cycle applies only to the next request
        xact({4'h2, 25'h0000123, 2'd0, 2'b11, 3'b0}, 1'b1, 32'hCAFE_F00D, 0, 1'b1, 5'h0B);
        xact({4'h2, 25'h0000123, 2'd2, 2'b00, 3'b0}, 1'b0, 0, 32'h00AB_0000, 1'b0, 0);
        chk("R4 new ext used next", 32'(ext_model), 32'h0B);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule